// File: doc/BRIEF.md
# Carry-Safe Split Counter Reader

This block takes a 64-bit snapshot of a free-running counter that can only be read one 32-bit half at a time, through a request/response port. A carry can move from the lower half into the upper half between two half-reads. Two such reads could therefore pair an old upper half with a new lower half. The reader avoids this by reading in a fixed order: first the upper half, then the lower half, then the upper half again. It keeps the result only when the two upper readings agree. When they differ, it runs the whole pass again from the first upper read.

A single-cycle start request launches the sequence. Each half-read is a one-cycle request that carries a half-select, and the reader waits for the matching valid response before it issues the next request. When a pass is consistent, the block registers the agreed upper half together with the lower half of that same pass and raises a one-cycle done pulse. It also reports how many passes it had to throw away.

Top module: `split_snapshot_reader`

## Requirements
- R1: While synchronous reset is high and in the first cycle after it, the block is idle: `rd_req_o`, `busy_o` and `done_o` are 0, and `snap_o` and `retries_o` are 0.
- R2: A `start_i` pulse seen while idle causes a request in the next cycle with `rd_hi_o`=1 (1 selects the upper half, 0 the lower half). Within one pass the requests select the upper half, then the lower half, then the upper half.
- R3: Each request lasts exactly one cycle. No further request is issued until `rd_valid_i` has returned the response. `rd_valid_i` has no effect while the block is idle.
- R4: If the two upper readings of a pass are equal, `done_o` rises in the cycle after the final response, and `snap_o` = {second upper reading, lower reading of that pass}.
- R5: If the two upper readings of a pass differ, no done pulse follows. The next request selects the upper half and begins a new pass.
- R6: At done, `retries_o` holds the number of discarded passes of that snapshot, saturating at 2^RETRY_W-1.
- R7: `done_o` is high for exactly one cycle. `snap_o` and `retries_o` keep their values until the next completion.
- R8: A `start_i` pulse during a sequence is ignored: the requests, the result and the retry count are the same as they would be without it.
- R9: `busy_o` is high from the cycle after an accepted start until the done cycle, and it is low in the done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one snapshot |
| rd_req_o | output | 1 | One-cycle read request to the counter port |
| rd_hi_o | output | 1 | Half select of the request, 1 = upper |
| rd_valid_i | input | 1 | Response valid from the counter port |
| rd_data_i | input | DATA_W | Response data, one half of the counter |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| snap_o | output | 2*DATA_W | Consistent counter snapshot |
| retries_o | output | RETRY_W | Discarded passes of the last snapshot |

## Verification
The bench responds to each request from a running 64-bit model counter, using a random response latency. It is exercised with a counter far from any carry, so a single pass should succeed. It is also exercised with the lower half preloaded a few counts below wrap, so a carry lands in the middle of the reads and exposes a reader that skips the retry or combines halves from different passes. Directed runs force mismatching upper readings, from one pass up to more passes than the counter can hold, to separate correct counting from saturation. Stray starts during a sequence, stray responses while idle, and a reset in mid-sequence show that none of these disturbs the request order or the result.

// File: rtl/snap_pkg.sv
package snap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_UP1,
        ST_WAIT_UP1,
        ST_REQ_LOW,
        ST_WAIT_LOW,
        ST_REQ_UP2,
        ST_WAIT_UP2
    } seq_state_t;

    typedef struct packed {
        logic req;
        logic upper;
    } rd_cmd_t;

    typedef struct packed {
        logic clr;
        logic cap_up;
        logic cap_low;
        logic accept;
        logic retry;
    } seq_ctl_t;

    function automatic rd_cmd_t cmd_for(seq_state_t s);
        rd_cmd_t c;
        c = '0;
        case (s)
            ST_REQ_UP1: begin c.req = 1'b1; c.upper = 1'b1; end
            ST_REQ_LOW: begin c.req = 1'b1; c.upper = 1'b0; end
            ST_REQ_UP2: begin c.req = 1'b1; c.upper = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic logic sat_inc_ok(logic [31:0] cur, logic [31:0] top);
        return cur != top;
    endfunction

endpackage

// File: rtl/snap_seq_fsm.sv
module snap_seq_fsm
    import snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rd_valid_i,
    input  logic              match_i,
    output snap_pkg::rd_cmd_t cmd_o,
    output snap_pkg::seq_ctl_t ctl_o,
    output logic              busy_o,
    output logic              done_o
);

    seq_state_t state_q, state_d;
    logic       done_q;

    always_comb begin
        ctl_o         = '0;
        ctl_o.clr     = (state_q == ST_IDLE) && start_i;
        ctl_o.cap_up  = (state_q == ST_WAIT_UP1) && rd_valid_i;
        ctl_o.cap_low = (state_q == ST_WAIT_LOW) && rd_valid_i;
        ctl_o.accept  = (state_q == ST_WAIT_UP2) && rd_valid_i && match_i;
        ctl_o.retry   = (state_q == ST_WAIT_UP2) && rd_valid_i && !match_i;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_REQ_UP1;
            ST_REQ_UP1:  state_d = ST_WAIT_UP1;
            ST_WAIT_UP1: if (rd_valid_i) state_d = ST_REQ_LOW;
            ST_REQ_LOW:  state_d = ST_WAIT_LOW;
            ST_WAIT_LOW: if (rd_valid_i) state_d = ST_REQ_UP2;
            ST_REQ_UP2:  state_d = ST_WAIT_UP2;
            ST_WAIT_UP2: if (rd_valid_i) state_d = match_i ? ST_IDLE : ST_REQ_UP1;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= ctl_o.accept;
        end
    end

    assign cmd_o  = cmd_for(state_q);
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;

    // R2
    first_req_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i) |=> (cmd_o.req && cmd_o.upper));

    // R3
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_o.req |=> !cmd_o.req);

    // R3
    wait_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_LOW && !rd_valid_i) |=> (state_q == ST_WAIT_LOW && !cmd_o.req));

    // R5
    retry_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_o.retry |=> (cmd_o.req && cmd_o.upper && !done_q));

    // R8
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !rd_valid_i) |=> busy_o);

endmodule

// File: rtl/snap_capture.sv
module snap_capture #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DATA_W-1:0]     rd_data_i,
    input  logic                  cap_up_i,
    input  logic                  cap_low_i,
    input  logic                  accept_i,
    output logic                  match_o,
    output logic [2*DATA_W-1:0]   snap_o
);

    localparam int SNAP_W = 2 * DATA_W;

    logic [DATA_W-1:0] up_q;
    logic [DATA_W-1:0] low_q;
    logic [SNAP_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q   <= '0;
            low_q  <= '0;
            snap_q <= '0;
        end else begin
            if (cap_up_i)  up_q   <= rd_data_i;
            if (cap_low_i) low_q  <= rd_data_i;
            if (accept_i)  snap_q <= {rd_data_i, low_q};
        end
    end

    assign match_o = (rd_data_i == up_q);
    assign snap_o  = snap_q;

    // R4
    snap_upper_agrees_chk: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> (snap_q[SNAP_W-1:DATA_W] == up_q));

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> $stable(snap_q));

endmodule

// File: rtl/snap_retry_ctr.sv
module snap_retry_ctr #(
    parameter int RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic               inc_i,
    input  logic               pub_i,
    output logic [RETRY_W-1:0] count_o
);

    localparam logic [RETRY_W-1:0] CNT_MAX = '1;

    logic [RETRY_W-1:0] run_q;
    logic [RETRY_W-1:0] pub_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            pub_q <= '0;
        end else begin
            if (clr_i)
                run_q <= '0;
            else if (inc_i && (run_q != CNT_MAX))
                run_q <= run_q + 1'b1;
            if (pub_i)
                pub_q <= run_q;
        end
    end

    assign count_o = pub_q;

    // R6
    retry_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q == CNT_MAX && !clr_i) |=> (run_q == CNT_MAX));

    // R7
    retry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pub_i |=> $stable(pub_q));

endmodule

// File: rtl/split_snapshot_reader.sv
module split_snapshot_reader
    import snap_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int RETRY_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    output logic                  rd_req_o,
    output logic                  rd_hi_o,
    input  logic                  rd_valid_i,
    input  logic [DATA_W-1:0]     rd_data_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [2*DATA_W-1:0]   snap_o,
    output logic [RETRY_W-1:0]    retries_o
);

    rd_cmd_t  cmd;
    seq_ctl_t ctl;
    logic     match;

    snap_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .rd_valid_i (rd_valid_i),
        .match_i    (match),
        .cmd_o      (cmd),
        .ctl_o      (ctl),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    snap_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .rd_data_i (rd_data_i),
        .cap_up_i  (ctl.cap_up),
        .cap_low_i (ctl.cap_low),
        .accept_i  (ctl.accept),
        .match_o   (match),
        .snap_o    (snap_o)
    );

    snap_retry_ctr #(.RETRY_W(RETRY_W)) u_retry (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (ctl.clr),
        .inc_i   (ctl.retry),
        .pub_i   (ctl.accept),
        .count_o (retries_o)
    );

    assign rd_req_o = cmd.req;
    assign rd_hi_o  = cmd.upper;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

// File: tb/split_snapshot_reader_test.sv
module split_snapshot_reader_test;

    localparam int DW = 32;
    localparam int RW = 8;
    localparam int RMAX = (1 << RW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          rd_valid_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          rd_req_o, rd_hi_o, busy_o, done_o;
    logic [2*DW-1:0] snap_o;
    logic [RW-1:0] retries_o;

    logic [63:0] tb_cnt;
    logic        tb_load = 1'b0;
    logic [63:0] tb_load_val = '0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    always @(posedge clk) tb_cnt <= tb_load ? tb_load_val : tb_cnt + 64'd1;

    split_snapshot_reader #(.DATA_W(DW), .RETRY_W(RW)) uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .rd_req_o(rd_req_o), .rd_hi_o(rd_hi_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o),
        .snap_o(snap_o), .retries_o(retries_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int sat_add(input int v);
        return (v >= RMAX) ? RMAX : v + 1;
    endfunction

    task automatic load_cnt(input logic [63:0] v);
        @(negedge clk);
        tb_load = 1'b1; tb_load_val = v;
        @(negedge clk);
        tb_load = 1'b0;
    endtask

    // One snapshot with a bench-side responder. forced: passes whose second
    // upper reading is made to differ. inject: stray start during a pass.
    task automatic run_snap(input int forced, input bit inject);
        int idx = 0;
        int exp_retry = 0;
        int left = forced;
        bit fin = 0;
        logic [31:0] h1 = '0, lo = '0, h2 = '0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o == 1'b1, "R9 busy after start", {63'd0, busy_o}, 64'd1);
        while (!fin) begin
            int wd = 0;
            int d;
            while (!rd_req_o && wd < 50) begin
                @(negedge clk); wd++;
            end
            if (wd >= 50) begin
                chk(1'b0, "R3 request missing", 64'd0, 64'd1);
                return;
            end
            chk(rd_hi_o == (idx != 1), "R2 half order", {63'd0, rd_hi_o}, {63'd0, idx != 1});
            chk(done_o == 1'b0, "R5 no done mid sequence", {63'd0, done_o}, 64'd0);
            d = 1 + int'($urandom % 3);
            for (int k = 0; k < d; k++) begin
                @(negedge clk);
                if (inject && idx == 1 && k == 0) start_i = 1'b1;
                else start_i = 1'b0;
                chk(rd_req_o == 1'b0, "R3 no request while waiting", {63'd0, rd_req_o}, 64'd0);
            end
            start_i = 1'b0;
            if (idx == 0) begin h1 = tb_cnt[63:32]; rd_data_i = h1; end
            else if (idx == 1) begin lo = tb_cnt[31:0]; rd_data_i = lo; end
            else begin
                h2 = tb_cnt[63:32];
                if (left > 0) begin h2 = h1 + 32'd1; left--; end
                rd_data_i = h2;
            end
            rd_valid_i = 1'b1;
            @(negedge clk);
            rd_valid_i = 1'b0;
            rd_data_i = $urandom;
            if (idx == 2) begin
                if (h1 == h2) begin
                    fin = 1;
                    chk(done_o == 1'b1, "R4 done after agreeing pass", {63'd0, done_o}, 64'd1);
                    chk(snap_o == {h2, lo}, "R4 snapshot value", snap_o, {h2, lo});
                    chk(retries_o == RW'(exp_retry), "R6 retry count", {56'd0, retries_o}, 64'(exp_retry));
                    chk(busy_o == 1'b0, "R9 not busy at done", {63'd0, busy_o}, 64'd0);
                    @(negedge clk);
                    chk(done_o == 1'b0, "R7 done one cycle", {63'd0, done_o}, 64'd0);
                    chk(snap_o == {h2, lo}, "R7 snapshot held", snap_o, {h2, lo});
                end else begin
                    exp_retry = sat_add(exp_retry);
                    chk(done_o == 1'b0, "R5 no done on mismatch", {63'd0, done_o}, 64'd0);
                end
            end
            idx = (idx + 1) % 3;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd91357));
        tb_load = 1'b1; tb_load_val = 64'h0000_0005_0000_0100;
        repeat (3) @(negedge clk);
        tb_load = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({rd_req_o, busy_o, done_o} == 3'b000, "R1 idle controls", {61'd0, rd_req_o, busy_o, done_o}, 64'd0);
        chk(snap_o == '0, "R1 snapshot zero", snap_o, 64'd0);
        chk(retries_o == '0, "R1 retries zero", {56'd0, retries_o}, 64'd0);

        // plain pass, far from a carry
        run_snap(0, 1'b0);
        // R5 carry placed in the middle of the reads
        load_cnt(64'h0000_0010_FFFF_FFFA);
        run_snap(0, 1'b0);
        // R5 forced mismatches
        run_snap(1, 1'b0);
        run_snap(3, 1'b0);
        // R8 stray start during a pass
        run_snap(2, 1'b1);

        // R3 response while idle has no effect
        held = snap_o;
        @(negedge clk); rd_valid_i = 1'b1; rd_data_i = 32'hDEAD_BEEF;
        @(negedge clk); rd_valid_i = 1'b0;
        @(negedge clk);
        chk({rd_req_o, busy_o, done_o} == 3'b000, "R3 idle valid ignored", {61'd0, rd_req_o, busy_o, done_o}, 64'd0);
        chk(snap_o == held, "R3 idle valid keeps snapshot", snap_o, held);

        // R6 saturation
        run_snap(RMAX + 5, 1'b0);

        // random mix
        for (int n = 0; n < 20; n++) begin
            if ($urandom % 2) load_cnt({32'($urandom), 32'hFFFF_FFF0 + 32'($urandom % 12)});
            else load_cnt({32'($urandom), 32'($urandom)});
            run_snap(int'($urandom % 3), 1'($urandom % 2));
        end

        // R1 reset in mid-sequence
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk({rd_req_o, busy_o, done_o} == 3'b000, "R1 reset mid sequence", {61'd0, rd_req_o, busy_o, done_o}, 64'd0);
        chk(snap_o == '0, "R1 snapshot cleared", snap_o, 64'd0);
        run_snap(0, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule